// File: doc/BRIEF.md
# Paired Single/Double Floating-Point Register File

This block is the floating-point register file of a 32-bit load/store processor. It holds thirty-two 32-bit words. The same storage can be seen as thirty-two single-precision registers or as sixteen 64-bit double-precision registers. Each double register is an even/odd pair of words and is named by its even index. In a double value, the even word supplies the upper 32 bits and the odd word supplies the lower 32 bits.

There are two combinational read ports and one write port. A precision flag on each port selects a single or a double access. A double write updates both words of the pair on the same clock edge. A double read returns both words at once. When a double access names an odd index, the block flags it as an error and does not act on it. A read of a word that is being written in the same cycle returns the incoming value, so an issue stage needs no bypass of its own.

Top module: `fpr_pair_file`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, all 32 words become zero. After that, every single or double read returns zero until a write occurs.
- R2: A single write (`wr_en`=1, `wr_dbl`=0) stores `wr_data[31:0]` into word `wr_idx` at the clock edge. Bits 63:32 of `wr_data` are ignored, and no other word changes.
- R3: A double write to an even `wr_idx` stores `wr_data[63:32]` into word `wr_idx` and `wr_data[31:0]` into word `wr_idx+1` on the same edge.
- R4: A double write to an odd `wr_idx` drives `wr_err` high in that cycle and changes no word. `wr_err` is low in every other cycle.
- R5: A single read (`rd_dbl[p]`=0) returns word `rd_idx[p]` on bits 31:0 of its port and zero on bits 63:32.
- R6: A double read of an even index returns the even word on bits 63:32 and the odd word on bits 31:0.
- R7: A double read of an odd index drives `rd_err[p]` high and returns all-zero data. `rd_err[p]` is low otherwise.
- R8: A read of any word that a legal write targets in the same cycle returns the value being written. This applies to each half of a double read on its own.
- R9: When `wr_en` is low, no word changes, whatever `wr_dbl`, `wr_idx` and `wr_data` hold.
- R10: The two read ports are independent. Each port has its own index and precision, and port p uses slice `[p*5 +: 5]` of `rd_idx` and `[p*64 +: 64]` of `rd_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low clear of all words |
| wr_en | input | 1 | Write request |
| wr_dbl | input | 1 | Write precision: 1 = double pair, 0 = single word |
| wr_idx | input | 5 | Write word index (even for double) |
| wr_data | input | 64 | Write value; single uses bits 31:0 |
| wr_err | output | 1 | Illegal double write (odd index) this cycle |
| rd_dbl | input | 2 | Per-port read precision |
| rd_idx | input | 10 | Per-port read index, 5 bits each |
| rd_data | output | 128 | Per-port read value, 64 bits each |
| rd_err | output | 2 | Per-port illegal double read |

## Verification
The hardest cases to create from the ports are those where a write and a read overlap in only part of a pair. One case is a single write into one half of a pair that a port reads as a double in the same cycle. Another is a double write that covers a word a port reads as a single. In both cases one half must come from the write and the other from storage. The bench first drives these overlaps with directed cycles on both halves of several pairs. It then runs a long stretch of random cycles in which the read indices are often copied from the write index, so that partial overlaps and odd-index double accesses recur. On every cycle, a behavioural word array in the bench predicts both ports and the error flags.

// File: rtl/fpr_pkg.sv
// Package: shared constants and helpers for the paired register file.
// Assumes a fixed 32-bit word; the double view is always two words.
package fpr_pkg;

    localparam int unsigned FPR_WORD_W = 32;

    typedef enum logic {
        PREC_SINGLE = 1'b0,
        PREC_DOUBLE = 1'b1
    } fpr_prec_e;

    // A double access needs an even index; a single access is always legal.
    function automatic logic fpr_access_ok(input logic dbl, input logic idx_lsb);
        return !(dbl && idx_lsb);
    endfunction

endpackage

// File: rtl/fpr_wr_decode.sv
// Module: fpr_wr_decode
// Turns one write request into a per-word hit vector and per-word value.
// Assumes NUM_REGS is even and a power of two; a double write to an odd
// index is refused (no hits) and reported on wr_err.
module fpr_wr_decode
    import fpr_pkg::*;
#(
    parameter int unsigned WORD_W   = FPR_WORD_W,
    parameter int unsigned NUM_REGS = 32,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS),
    localparam int unsigned DW      = 2 * WORD_W
) (
    input  logic                               wr_en,
    input  logic                               wr_dbl,
    input  logic [IDX_W-1:0]                   wr_idx,
    input  logic [DW-1:0]                      wr_data,
    output logic [NUM_REGS-1:0]                hit,
    output logic [NUM_REGS-1:0][WORD_W-1:0]    val,
    output logic                               wr_err
);

    logic legal;
    logic go;

    // Legality of the request and the qualified write strobe.
    always_comb begin
        legal  = fpr_access_ok(wr_dbl, wr_idx[0]);
        go     = wr_en && legal;
        wr_err = wr_en && !legal;
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        localparam logic [IDX_W-1:0] SELF = IDX_W'(g);
        localparam logic [IDX_W-2:0] PAIR = (IDX_W-1)'(g / 2);

        // Word g is hit by a single write to g or a double write to its pair.
        assign hit[g] = go && (wr_dbl ? (wr_idx[IDX_W-1:1] == PAIR)
                                      : (wr_idx == SELF));

        // Even words take the upper half of a double; all else takes the lower.
        if ((g % 2) == 0) begin : g_even
            assign val[g] = wr_dbl ? wr_data[DW-1:WORD_W] : wr_data[WORD_W-1:0];
        end else begin : g_odd
            assign val[g] = wr_data[WORD_W-1:0];
        end
    end

endmodule

// File: rtl/fpr_store.sv
// Module: fpr_store
// The word array with synchronous active-low clear and a forwarded view
// in which a word being written this cycle shows its incoming value.
// Assumes hit/val come from fpr_wr_decode (at most one pair hit).
module fpr_store #(
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned NUM_REGS = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_REGS-1:0]                hit,
    input  logic [NUM_REGS-1:0][WORD_W-1:0]    val,
    output logic [NUM_REGS-1:0][WORD_W-1:0]    q,
    output logic [NUM_REGS-1:0][WORD_W-1:0]    fwd
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        // Hold or update one word; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[g] <= '0;
            end else if (hit[g]) begin
                q[g] <= val[g];
            end
        end

        // Read-during-write view of one word.
        assign fwd[g] = hit[g] ? val[g] : q[g];

        AST_UNHIT_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            !hit[g] |=> $stable(q[g])); // R9
    end

    AST_RESET_CLEARS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (q == '0)); // R1

endmodule

// File: rtl/fpr_rd_port.sv
// Module: fpr_rd_port
// One combinational read port over the forwarded word view.
// Single reads zero-extend; double reads join even (high) and odd (low);
// an odd-index double read returns zero and raises err.
module fpr_rd_port
    import fpr_pkg::*;
#(
    parameter int unsigned WORD_W   = FPR_WORD_W,
    parameter int unsigned NUM_REGS = 32,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS),
    localparam int unsigned DW      = 2 * WORD_W
) (
    input  logic                               dbl,
    input  logic [IDX_W-1:0]                   idx,
    input  logic [NUM_REGS-1:0][WORD_W-1:0]    words,
    output logic [DW-1:0]                      data,
    output logic                               err
);

    logic [IDX_W-1:0] even_idx;
    logic [IDX_W-1:0] odd_idx;

    // Select and format the returned value.
    always_comb begin
        even_idx = {idx[IDX_W-1:1], 1'b0};
        odd_idx  = {idx[IDX_W-1:1], 1'b1};
        err      = !fpr_access_ok(dbl, idx[0]);
        if (err) begin
            data = '0;
        end else if (dbl) begin
            data = {words[even_idx], words[odd_idx]};
        end else begin
            data = {{WORD_W{1'b0}}, words[idx]};
        end
    end

endmodule

// File: rtl/fpr_pair_file.sv
// Module: fpr_pair_file
// Top: write decode, word store and NUM_RD read ports. All reads see
// same-cycle writes. Assumes a single writer per cycle.
module fpr_pair_file
    import fpr_pkg::*;
#(
    parameter int unsigned WORD_W   = FPR_WORD_W,
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned NUM_RD   = 2,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS),
    localparam int unsigned DW      = 2 * WORD_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      wr_dbl,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [DW-1:0]             wr_data,
    output logic                      wr_err,
    input  logic [NUM_RD-1:0]         rd_dbl,
    input  logic [NUM_RD*IDX_W-1:0]   rd_idx,
    output logic [NUM_RD*DW-1:0]      rd_data,
    output logic [NUM_RD-1:0]         rd_err
);

    logic [NUM_REGS-1:0]              hit;
    logic [NUM_REGS-1:0][WORD_W-1:0]  val;
    logic [NUM_REGS-1:0][WORD_W-1:0]  q;
    logic [NUM_REGS-1:0][WORD_W-1:0]  fwd;

    fpr_wr_decode #(.WORD_W(WORD_W), .NUM_REGS(NUM_REGS)) u_dec (
        .wr_en   (wr_en),
        .wr_dbl  (wr_dbl),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .hit     (hit),
        .val     (val),
        .wr_err  (wr_err)
    );

    fpr_store #(.WORD_W(WORD_W), .NUM_REGS(NUM_REGS)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .val   (val),
        .q     (q),
        .fwd   (fwd)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_port
        logic [IDX_W-1:0] p_idx;
        logic [DW-1:0]    p_data;
        logic             p_err;

        assign p_idx = rd_idx[p*IDX_W +: IDX_W];

        fpr_rd_port #(.WORD_W(WORD_W), .NUM_REGS(NUM_REGS)) u_port (
            .dbl   (rd_dbl[p]),
            .idx   (p_idx),
            .words (fwd),
            .data  (p_data),
            .err   (p_err)
        );

        assign rd_data[p*DW +: DW] = p_data;
        assign rd_err[p]           = p_err;

        AST_SINGLE_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_dbl[p] |-> (p_data[DW-1:WORD_W] == '0)); // R5
        AST_DOUBLE_MATCHES_STORE: assert property (@(posedge clk) disable iff (!rst_n)
            (!wr_en && rd_dbl[p] && !p_idx[0]) |->
            (p_data == {q[{p_idx[IDX_W-1:1], 1'b0}], q[{p_idx[IDX_W-1:1], 1'b1}]})); // R6
        AST_ODD_DOUBLE_READ_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_dbl[p] && p_idx[0]) |-> (p_err && (p_data == '0))); // R7
        AST_SINGLE_SEES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_dbl && !rd_dbl[p] && (wr_idx == p_idx)) |->
            (p_data[WORD_W-1:0] == wr_data[WORD_W-1:0])); // R8
    end

    AST_ODD_DOUBLE_WRITE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_dbl && wr_idx[0]) |-> wr_err); // R4
    AST_ODD_DOUBLE_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_dbl && wr_idx[0]) |=> $stable(q)); // R4
    AST_DOUBLE_WRITE_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_dbl && !wr_idx[0]) |=>
        ((q[$past(wr_idx)] == $past(wr_data[DW-1:WORD_W])) &&
         (q[$past(wr_idx) + 1'b1] == $past(wr_data[WORD_W-1:0])))); // R3
    AST_HIT_AT_MOST_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hit) <= 2); // R3

endmodule

// File: tb/fpr_pair_file_bench.sv
// Bench: behavioural word-array model compared with both ports on every cycle.
module fpr_pair_file_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic         wr_dbl = 1'b0;
    logic [4:0]   wr_idx = '0;
    logic [63:0]  wr_data = '0;
    logic         wr_err;
    logic [1:0]   rd_dbl = '0;
    logic [9:0]   rd_idx = '0;
    logic [127:0] rd_data;
    logic [1:0]   rd_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [31:0] m [32];

    always #5 clk = ~clk;

    fpr_pair_file u_fpr_pair_file (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dbl(wr_dbl),
        .wr_idx(wr_idx), .wr_data(wr_data), .wr_err(wr_err),
        .rd_dbl(rd_dbl), .rd_idx(rd_idx), .rd_data(rd_data), .rd_err(rd_err)
    );

    function automatic bit wr_legal();
        return wr_en && !(wr_dbl && wr_idx[0]);
    endfunction

    function automatic bit wr_touches(input int i);
        if (!wr_legal()) return 1'b0;
        if (wr_dbl) return (int'(wr_idx) >> 1) == (i >> 1);
        return int'(wr_idx) == i;
    endfunction

    // Word value a read should see this cycle (stored or incoming).
    function automatic logic [31:0] seen(input int i);
        if (wr_touches(i)) begin
            if (wr_dbl && (i % 2 == 0)) return wr_data[63:32];
            return wr_data[31:0];
        end
        return m[i];
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string note);
        for (int p = 0; p < 2; p++) begin
            int i = int'(rd_idx[p*5 +: 5]);
            bit d = rd_dbl[p];
            logic [63:0] ed;
            string tag;
            if (d && i[0]) begin
                ed = '0; tag = "R7";
            end else if (d) begin
                ed = {seen(i), seen(i + 1)};
                tag = (wr_touches(i) || wr_touches(i + 1)) ? "R8" : "R6";
            end else begin
                ed = {32'h0, seen(i)};
                tag = wr_touches(i) ? "R8" : "R5";
            end
            if (note != "") tag = note;
            check(tag, $sformatf("port%0d data", p), rd_data[p*64 +: 64], ed);
            check(tag, $sformatf("port%0d err", p), {63'h0, rd_err[p]},
                  {63'h0, (d && i[0])});
        end
        check("R4", "wr_err", {63'h0, wr_err}, {63'h0, (wr_en && wr_dbl && wr_idx[0])});
    endtask

    // One cycle: drive at the falling edge, compare, then advance the model.
    task automatic step(input logic rn, input logic we, input logic wd,
                        input logic [4:0] wi, input logic [63:0] wdat,
                        input logic d0, input logic [4:0] i0,
                        input logic d1, input logic [4:0] i1, input string note);
        @(negedge clk);
        rst_n = rn; wr_en = we; wr_dbl = wd; wr_idx = wi; wr_data = wdat;
        rd_dbl = {d1, d0}; rd_idx = {i1, i0};
        #1;
        if (rst_n) compare_all(note);
        if (!rst_n) begin
            for (int k = 0; k < 32; k++) m[k] = '0;
        end else if (wr_legal()) begin
            if (wr_dbl) begin
                m[wr_idx] = wr_data[63:32];
                m[wr_idx + 5'd1] = wr_data[31:0];
            end else begin
                m[wr_idx] = wr_data[31:0];
            end
        end
    endtask

    task automatic idle_read(input logic d0, input logic [4:0] i0,
                             input logic d1, input logic [4:0] i1, input string note);
        step(1'b1, 1'b0, 1'b0, 5'd0, 64'h0, d0, i0, d1, i1, note);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset, then every word reads zero in both views.
        step(1'b0, 1'b0, 1'b0, 5'd0, 64'h0, 1'b0, 5'd0, 1'b0, 5'd0, "");
        step(1'b0, 1'b0, 1'b0, 5'd0, 64'h0, 1'b0, 5'd0, 1'b0, 5'd0, "");
        for (int k = 0; k < 32; k++)
            idle_read(1'b0, 5'(k), 1'b1, 5'(k & 30), "R1");

        // R2: single writes; upper data bits must be ignored.
        for (int k = 0; k < 32; k++)
            step(1'b1, 1'b1, 1'b0, 5'(k), {32'hDEAD0000 + 32'(k), 32'hA5000100 + 32'(k * 3)},
                 1'b0, 5'((k + 31) % 32), 1'b0, 5'(k ^ 1), "R2");
        // R5 and R6 on the filled array.
        for (int k = 0; k < 32; k += 2)
            idle_read(1'b1, 5'(k), 1'b0, 5'(k + 1), "");

        // R3: double writes to every pair, read back next cycle.
        for (int k = 0; k < 32; k += 2) begin
            step(1'b1, 1'b1, 1'b1, 5'(k), {32'h11110000 + 32'(k), 32'h22220000 + 32'(k)},
                 1'b0, 5'(k ^ 2), 1'b0, 5'(k ^ 3), "R3");
            idle_read(1'b1, 5'(k), 1'b0, 5'(k + 1), "R3");
        end

        // R4: odd-index double writes are refused.
        for (int k = 1; k < 32; k += 6) begin
            step(1'b1, 1'b1, 1'b1, 5'(k), 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 5'(k), 1'b1, 5'(k - 1), "R4");
            idle_read(1'b1, 5'(k - 1), 1'b0, 5'(k), "R4");
        end

        // R9: disabled write with live-looking fields.
        step(1'b1, 1'b0, 1'b1, 5'd4, 64'h0BAD_0BAD_0BAD_0BAD, 1'b1, 5'd4, 1'b0, 5'd5, "R9");
        step(1'b1, 1'b0, 1'b0, 5'd7, 64'h0BAD_0BAD_0BAD_0BAD, 1'b0, 5'd7, 1'b1, 5'd4, "R9");
        idle_read(1'b1, 5'd4, 1'b0, 5'd7, "R9");

        // R8: partial overlaps in both directions.
        step(1'b1, 1'b1, 1'b0, 5'd9, 64'h0000_0000_CAFE_0009, 1'b1, 5'd8, 1'b0, 5'd9, "R8");
        step(1'b1, 1'b1, 1'b0, 5'd12, 64'h0000_0000_CAFE_000C, 1'b1, 5'd12, 1'b1, 5'd14, "R8");
        step(1'b1, 1'b1, 1'b1, 5'd20, 64'h1234_5678_9ABC_DEF0, 1'b0, 5'd21, 1'b0, 5'd20, "R8");
        step(1'b1, 1'b1, 1'b1, 5'd30, 64'h0F0F_0F0F_F0F0_F0F0, 1'b1, 5'd30, 1'b0, 5'd31, "R8");

        // R7: odd-index double reads.
        idle_read(1'b1, 5'd3, 1'b1, 5'd31, "R7");

        // R10: ports with different precisions and indices.
        idle_read(1'b1, 5'd20, 1'b0, 5'd9, "R10");
        idle_read(1'b0, 5'd30, 1'b1, 5'd8, "R10");

        // Random traffic with frequent index sharing.
        for (int n = 0; n < 3000; n++) begin
            logic [4:0] wi = 5'($urandom_range(0, 31));
            logic [4:0] a  = ($urandom_range(0, 2) == 0) ? wi : 5'($urandom_range(0, 31));
            logic [4:0] b  = ($urandom_range(0, 2) == 0) ? (wi ^ 5'd1) : 5'($urandom_range(0, 31));
            step(1'b1, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), wi,
                 {$urandom(), $urandom()}, 1'($urandom_range(0, 1)), a,
                 1'($urandom_range(0, 1)), b, "");
        end

        // R1: reset in mid-run clears everything again.
        step(1'b0, 1'b1, 1'b0, 5'd3, 64'h5555, 1'b0, 5'd0, 1'b0, 5'd0, "");
        for (int k = 0; k < 32; k += 2)
            idle_read(1'b1, 5'(k), 1'b0, 5'(k + 1), "R1");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule